// File: doc/BRIEF.md
# Status-Decoded Clock Stop Controller

This block decides when a system's clock outputs, and in crystal mode also its oscillator, are halted and when they come back. It runs on the master oscillator (or external frequency) clock `mclk`. From it, it derives a processor clock, a near-50% companion clock and a peripheral clock at one sixth of `mclk`. Three active-low status lines are sampled on every rising edge of the processor clock. A stop is recognised only when a halt code follows a passive code on consecutive samples. After a stop is committed, the processor clocks run two further full periods and then park high, and the peripheral clock freezes. In crystal mode the oscillator enable is also dropped.

A restart comes from a high `start` or a low `res_n`. Both pass through a two-flop synchroniser on `mclk`. In crystal mode a restart raises the oscillator enable. The clocks then stay parked until a programmable number of valid oscillator cycles has been counted, and reset activity does not disturb that count. In external-frequency mode the clocks resume a few cycles after the synchronised start, and the oscillator enable never drops. The speed choice (divide by `DIV_FAST` or `DIV_SLOW`) is latched only at processor clock rising edges. A restart therefore resumes in the speed that was in force at the stop.

Top module: `clk_stop_ctrl`

## Requirements
- R1: A stop is committed only at a processor clock rising edge whose status sample `stat` equals 3'b011 (bit 2 = stop line low, bits 1 and 0 high) and whose previous rising-edge sample equals the passive code 3'b111; every other pair of samples leaves the clocks running.
- R2: After a committed stop, `clk_o` shows exactly two more rising edges and then stays high, with `clk50_o` also high.
- R3: `pclk_o` toggles every 3 `mclk` cycles while running, whatever the speed, and holds its level while stopped.
- R4: With `efi_mode` low, a stop drops `osc_en`; with `efi_mode` high, `osc_en` stays high through a stop.
- R5: While the synchronised `start` is high, the 3'b111 then 3'b011 sequence does not stop the clocks.
- R6: A stopped block restarts when `start` is high or when `res_n` is low, each seen after a two-flop synchroniser.
- R7: In crystal mode, after `osc_en` rises, the clocks stay parked until `WARM_CYC` cycles with `osc_valid` high have passed; `clk_o` first falls on the (`WARM_CYC`+1+G)-th `mclk` edge, where G is the number of those edges with `osc_valid` low.
- R8: In external-frequency mode, `clk_o` first falls on the fourth `mclk` rising edge after `start` is raised in a stopped state.
- R9: `fast_sel` is sampled only at processor clock rising edges while running, so a restart runs its first period at the speed held when the stop happened.
- R10: `res_n` activity during the crystal warm-up does not change the length of the count.
- R11: After `por_n` releases, `osc_en`, `clk_o` and `clk50_o` are high, `pclk_o` is low, and the block starts in the warm-up of R7.
- R12: The processor clock period is `DIV_FAST` (fast) or `DIV_SLOW` (slow) `mclk` cycles, high for one third of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master oscillator / external frequency clock |
| por_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| efi_mode | input | 1 | 1 = external-frequency source, 0 = crystal |
| fast_sel | input | 1 | 1 = fast divide, 0 = slow divide |
| osc_valid | input | 1 | Oscillator amplitude has crossed the input threshold |
| start | input | 1 | Restart request, active high, asynchronous |
| res_n | input | 1 | Reset request, active low, asynchronous |
| stat | input | 3 | Status lines {stop, s1, s0}, active low |
| clk_o | output | 1 | Processor clock, one-third duty |
| clk50_o | output | 1 | Companion clock, near 50% duty |
| pclk_o | output | 1 | Peripheral clock, mclk divided by 6 |
| osc_en | output | 1 | Oscillator enable |

## Verification
Status changes are applied just after an observed processor clock rise, so each sample falls on the next rise and a committed stop shows exactly two further rises within a fixed window. A start raised in external-frequency mode needs two synchroniser edges and one state edge, and the clock falls on the fourth edge. A crystal restart is measured from the cycle `osc_en` is seen high, and the expected count is `WARM_CYC`+1 plus the number of edges on which the bench held `osc_valid` low. Pulse widths are counted in `mclk` steps between observed transitions, with every output sampled on the falling edge of `mclk`.

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int DIV_FAST = 3,
  parameter int DIV_SLOW = 768,
  parameter int WARM_CYC = 8192
) (
  input  logic       mclk,
  input  logic       por_n,
  input  logic       efi_mode,
  input  logic       fast_sel,
  input  logic       osc_valid,
  input  logic       start,
  input  logic       res_n,
  input  logic [2:0] stat,
  output logic       clk_o,
  output logic       clk50_o,
  output logic       pclk_o,
  output logic       osc_en
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam int WW = $clog2(WARM_CYC + 1);

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_PEND = 2'd1, ST_HALT = 2'd2, ST_WARM = 2'd3} st_t;

  st_t           st;
  logic [1:0]    start_sy, res_sy;
  logic [PW-1:0] phase;
  logic          fast_q, prev_idle, pend_n, pclk_q;
  logic [1:0]    pcnt;
  logic [WW-1:0] wcnt;

  wire start_s = start_sy[1];
  wire res_low = !res_sy[1];
  wire ticking = (st == ST_RUN) || (st == ST_PEND);
  wire [PW-1:0] div_m1 = fast_q ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  wire [PW-1:0] hi_len = fast_q ? PW'(DIV_FAST / 3) : PW'(DIV_SLOW / 3);
  wire [PW-1:0] h50_len = fast_q ? PW'((DIV_FAST + 1) / 2) : PW'((DIV_SLOW + 1) / 2);
  wire rise = ticking && (phase == div_m1);
  wire halt_code = (stat == 3'b011);
  wire idle_code = (stat == 3'b111);

  assign clk_o   = phase < hi_len;
  assign clk50_o = phase < h50_len;
  assign pclk_o  = pclk_q;
  assign osc_en  = !((st == ST_HALT) && !efi_mode);

  always_ff @(posedge mclk or negedge por_n) begin
    if (!por_n) begin
      st        <= ST_WARM;
      start_sy  <= 2'b00;
      res_sy    <= 2'b11;
      phase     <= '0;
      fast_q    <= 1'b1;
      prev_idle <= 1'b0;
      pend_n    <= 1'b0;
      pcnt      <= 2'd0;
      pclk_q    <= 1'b0;
      wcnt      <= '0;
    end else begin
      start_sy <= {start_sy[0], start};
      res_sy   <= {res_sy[0], res_n};
      if (ticking) begin
        phase <= rise ? '0 : phase + 1'b1;
        pcnt  <= (pcnt == 2'd2) ? 2'd0 : pcnt + 2'd1;
        if (pcnt == 2'd2) pclk_q <= ~pclk_q;
      end
      if (rise) begin
        fast_q    <= fast_sel;
        prev_idle <= idle_code;
      end
      case (st)
        ST_RUN: begin
          if (rise && halt_code && prev_idle && !start_s) begin
            st     <= ST_PEND;
            pend_n <= 1'b0;
          end
        end
        ST_PEND: begin
          if (start_s) st <= ST_RUN;
          else if (rise) begin
            if (pend_n) st <= ST_HALT;
            else pend_n <= 1'b1;
          end
        end
        ST_HALT: begin
          if (start_s || res_low) begin
            if (efi_mode) st <= ST_RUN;
            else begin
              st   <= ST_WARM;
              wcnt <= '0;
            end
          end
        end
        ST_WARM: begin
          if (efi_mode) st <= ST_RUN;
          else if (osc_valid) begin
            if (wcnt == WW'(WARM_CYC - 1)) st <= ST_RUN;
            else wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= ST_WARM;
      endcase
    end
  end
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk (
  input logic       mclk,
  input logic       por_n,
  input logic       efi_mode,
  input logic       start_s,
  input logic [1:0] st,
  input logic       clk_o,
  input logic       clk50_o,
  input logic       pclk_o,
  input logic       osc_en
);
  a_r4_osc_off_parked: assert property (@(posedge mclk) disable iff (!por_n)
    !osc_en |-> (clk_o && clk50_o && !efi_mode));

  a_r3_pclk_frozen: assert property (@(posedge mclk) disable iff (!por_n)
    !osc_en |=> $stable(pclk_o));

  a_r7_warm_parked: assert property (@(posedge mclk) disable iff (!por_n)
    (st == 2'd3) |-> (clk_o && clk50_o && osc_en));

  a_r5_start_blocks_stop: assert property (@(posedge mclk) disable iff (!por_n)
    (start_s && st == 2'd0) |=> (st == 2'd0));

  a_r2_halt_parked: assert property (@(posedge mclk) disable iff (!por_n)
    (st == 2'd2) |=> ((st != 2'd2) || ($stable(pclk_o) && clk_o)));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk u_chk (
  .mclk(mclk), .por_n(por_n), .efi_mode(efi_mode), .start_s(start_s),
  .st(st), .clk_o(clk_o), .clk50_o(clk50_o), .pclk_o(pclk_o), .osc_en(osc_en)
);

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_ctrl_tb;
  localparam int DF = 3;
  localparam int DS = 12;
  localparam int W  = 40;

  logic mclk = 1'b0, por_n = 1'b0, efi_mode = 1'b0, fast_sel = 1'b1;
  logic osc_valid = 1'b1, start = 1'b0, res_n = 1'b1;
  logic [2:0] stat = 3'b111;
  wire clk_o, clk50_o, pclk_o, osc_en;
  int n_run = 0, n_fail = 0;

  always #4 mclk = ~mclk;

  clk_stop_ctrl #(.DIV_FAST(DF), .DIV_SLOW(DS), .WARM_CYC(W)) u_dut (
    .mclk(mclk), .por_n(por_n), .efi_mode(efi_mode), .fast_sel(fast_sel),
    .osc_valid(osc_valid), .start(start), .res_n(res_n), .stat(stat),
    .clk_o(clk_o), .clk50_o(clk50_o), .pclk_o(pclk_o), .osc_en(osc_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge mclk);
  endtask

  task automatic wait_rise();
    bit p;
    for (int i = 0; i < 4 * DS; i++) begin
      p = clk_o;
      step();
      if (!p && clk_o) return;
    end
    chk(1'b0, "R12 clock rise seen", 0, 1);
  endtask

  task automatic meas_low(output int n);
    int g;
    g = 0;
    while (clk_o && g < 200) begin step(); g++; end
    n = 0;
    while (!clk_o && n < 200) begin step(); n++; end
  endtask

  task automatic stop_seq(input logic [2:0] a, input logic [2:0] b, input int win,
                          output int rises, output bit pst);
    bit p;
    logic pc;
    wait_rise(); stat = 3'b000;
    wait_rise(); stat = a;
    wait_rise(); stat = b;
    wait_rise(); stat = 3'b000;
    rises = 0; pst = 1'b1; pc = pclk_o;
    for (int i = 0; i < win; i++) begin
      p = clk_o;
      step();
      if (!p && clk_o) rises++;
      if (i == win / 2) pc = pclk_o;
      if (i > win / 2 && pclk_o != pc) pst = 1'b0;
    end
  endtask

  task automatic restart_xtal(input bit by_start, input int gap, output int n);
    int g;
    osc_valid = 1'b0;
    if (by_start) start = 1'b1; else res_n = 1'b0;
    g = 0;
    while (!osc_en && g < 10) begin step(); g++; end
    n = 0;
    while (n < 400) begin
      if (n == gap) osc_valid = 1'b1;
      if (!by_start) res_n = n[0];
      step();
      n++;
      if (!clk_o) break;
    end
    start = 1'b0; res_n = 1'b1; osc_valid = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, r;
    bit ps;
    logic pv;
    step(); step();
    por_n = 1'b1;
    chk(osc_en && clk_o && clk50_o && !pclk_o, "R11 reset outputs",
        {osc_en, clk_o, clk50_o, pclk_o}, 4'b1110);
    n = 0;
    do begin step(); n++; end while (clk_o && n < 200);
    chk(n == W + 1, "R7 R11 power-up warm-up length", n, W + 1);

    wait_rise(); meas_low(n);
    chk(n == DF - DF / 3, "R12 fast low time", n, DF - DF / 3);
    pv = pclk_o; n = 0;
    while (pclk_o == pv && n < 20) begin step(); n++; end
    pv = pclk_o; n = 0;
    while (pclk_o == pv && n < 20) begin step(); n++; end
    chk(n == 3, "R3 pclk half period fast", n, 3);

    fast_sel = 1'b0;
    wait_rise(); wait_rise();
    meas_low(n);
    chk(n == DS - DS / 3, "R12 R9 slow low time", n, DS - DS / 3);
    pv = pclk_o; n = 0;
    while (pclk_o == pv && n < 20) begin step(); n++; end
    pv = pclk_o; n = 0;
    while (pclk_o == pv && n < 20) begin step(); n++; end
    chk(n == 3, "R3 pclk half period slow", n, 3);
    fast_sel = 1'b1;
    wait_rise(); wait_rise();

    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        bit hit;
        hit = (a == 7) && (b == 3);
        stop_seq(3'(a), 3'(b), 40, r, ps);
        if (hit) begin
          chk(r == 2, "R1 R2 rises after valid stop", r, 2);
          chk(clk_o && clk50_o, "R2 parked high", {clk_o, clk50_o}, 2'b11);
          chk(ps, "R3 pclk frozen", ps, 1);
          chk(!osc_en, "R4 crystal osc off", osc_en, 0);
          restart_xtal(1'b1, 3, n);
          chk(n == 3 + W + 1, "R6 R7 start restart with gaps", n, 3 + W + 1);
        end else begin
          chk(r > 2, "R1 no stop for pair", r, 3);
        end
      end
    end

    start = 1'b1; step(); step(); step();
    stop_seq(3'b111, 3'b011, 40, r, ps);
    chk(r > 2, "R5 start suppresses stop", r, 3);
    start = 1'b0; step(); step(); step();

    stop_seq(3'b111, 3'b011, 40, r, ps);
    chk(r == 2 && !osc_en, "R2 R4 stop before reset restart", r, 2);
    restart_xtal(1'b0, 1, n);
    chk(n == 1 + W + 1, "R6 R10 res_n restart unaffected by res_n toggles", n, 1 + W + 1);

    efi_mode = 1'b1;
    wait_rise(); wait_rise();
    stop_seq(3'b111, 3'b011, 40, r, ps);
    chk(r == 2 && clk_o, "R2 efi stop parks", r, 2);
    chk(osc_en, "R4 efi keeps osc_en", osc_en, 1);
    start = 1'b1; n = 0;
    do begin step(); n++; end while (clk_o && n < 20);
    chk(n == 4, "R8 efi resume latency", n, 4);
    start = 1'b0; step(); step(); step();

    fast_sel = 1'b0;
    wait_rise(); wait_rise();
    stop_seq(3'b111, 3'b011, 80, r, ps);
    chk(r == 2 && ps, "R2 R3 slow stop", r, 2);
    fast_sel = 1'b1;
    repeat (5) step();
    start = 1'b1;
    meas_low(n);
    chk(n == DS - DS / 3, "R9 first period in saved slow speed", n, DS - DS / 3);
    start = 1'b0;
    meas_low(n);
    chk(n == DF - DF / 3, "R9 new speed after next rise", n, DF - DF / 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule